// File: doc/BRIEF.md
# Peripheral Request to Channel Router

The router sits between a set of peripheral transfer-request lines and the channels of a DMA engine. Each of the 75 request lines owns an 8-bit routing entry. The entry holds an enable flag and a target channel number, and software programs it over a simple 32-bit register bus. A request line whose entry is enabled steers its level onto the chosen channel. The channel's "request active" output then follows that level.

The router watches each routed line for level changes. When a line rises on a channel that was idle, the router pulses an "arrived after stop" event for that channel. When a line falls on a channel that was active, it pulses an "end of receive" event. The transfer engine and the channel status logic consume these outputs. They are not part of this block.

The routing entries sit in two windows of the register space. Entries 0 to 63 form one window and entries 64 to 74 form another. A write that enables an entry with a channel number the engine does not have is rejected and reported.

Top module: `req_router`

## Requirements
- R1: Each routing entry reads back as bit 7 = enable and bits 4:0 = channel number, with all other bits reading 0. After reset, every entry reads 0 (disabled, channel 0).
- R2: Entry k (k < 64) sits at byte address 0x100 + 4k. Entry k (64 ≤ k < 75) sits at 0x1100 + 4(k-64). Reads of any other address return 0, and writes to any other address change no entry.
- R3: A request line whose entry has the enable flag clear changes no channel output in either direction.
- R4: When an enabled line rises at a clock edge and its channel's active output is 0, that channel's ras_pulse is 1 for the one cycle that follows that edge.
- R5: When an enabled line falls at a clock edge and its channel's active output is 1, that channel's eor_pulse is 1 for the one cycle that follows that edge. ras_pulse and eor_pulse are never high together on a channel.
- R6: A channel's ch_active output takes the new level of its routed line in the cycle after the edge that samples the change. ch_active keeps its value while no routed line changes.
- R7: A write that sets the enable flag with a channel number ≥ NCH (16 by default) leaves the entry unchanged, and bus_err is 1 for the following cycle. An accepted write leaves bus_err at 0.
- R8: If several enabled lines routed to one channel change in the same cycle, the line with the highest index decides the level and the events.
- R9: During reset, and in the cycle after it, ch_active, ras_pulse, eor_pulse and bus_err are 0. A line that is already high when reset is released raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 75 | Peripheral request levels, one per line |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| bus_err | output | 1 | Rejected-write pulse |
| ch_active | output | 16 | Per-channel request active level |
| ras_pulse | output | 16 | Per-channel request-after-stop event |
| eor_pulse | output | 16 | Per-channel end-of-receive event |

## Verification
The checker tests four properties on every cycle:
- A rise event appears only on a channel that was idle and is now active.
- A fall event appears only on a channel that was active and is now idle.
- The two events never coincide on a channel.
- ch_active holds whenever the request lines stayed unchanged, and bus_err follows only a write.

Only the bench scenarios can show the rest. These are the address windows and the readback format, the effect of a disabled entry, the rejection of out-of-range channels, and which line wins when two lines routed to one channel collide.

// File: rtl/req_router.sv
module req_router #(
  parameter int NREQ = 75,
  parameter int NCH  = 16,
  parameter int CW   = 5,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter logic [15:0] LO_BASE = 16'h0100,
  parameter logic [15:0] HI_BASE = 16'h1100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_in,
  input  logic            bus_wen,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic [NCH-1:0]  ch_active,
  output logic [NCH-1:0]  ras_pulse,
  output logic [NCH-1:0]  eor_pulse
);
  localparam int LO_CNT = 64;
  localparam int HI_CNT = NREQ - LO_CNT;
  localparam int IW = $clog2(NREQ);
  localparam logic [AW-1:0] LO_END = AW'(LO_BASE) + AW'(4 * LO_CNT);
  localparam logic [AW-1:0] HI_END = AW'(HI_BASE) + AW'(4 * HI_CNT);

  logic [NREQ-1:0]         map_vld;
  logic [NREQ-1:0][CW-1:0] map_ch;
  logic [NREQ-1:0]         req_q;

  logic          hit;
  logic [IW-1:0] idx;
  logic [AW-1:0] off_lo, off_hi;

  assign off_lo = bus_addr - AW'(LO_BASE);
  assign off_hi = bus_addr - AW'(HI_BASE);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr >= AW'(LO_BASE) && bus_addr < LO_END) begin
        hit = 1'b1;
        idx = IW'(off_lo >> 2);
      end else if (bus_addr >= AW'(HI_BASE) && bus_addr < HI_END) begin
        hit = 1'b1;
        idx = IW'(LO_CNT) + IW'(off_hi >> 2);
      end
    end
  end

  logic wr_bad, wr_ok;
  assign wr_bad = bus_wdata[7] && (int'(bus_wdata[CW-1:0]) >= NCH);
  assign wr_ok  = bus_wen && hit && !wr_bad;

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[7]      = map_vld[idx];
      bus_rdata[CW-1:0] = map_ch[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_vld <= '0;
      map_ch  <= '0;
      bus_err <= 1'b0;
    end else begin
      bus_err <= bus_wen && hit && wr_bad;
      if (wr_ok) begin
        map_vld[idx] <= bus_wdata[7];
        map_ch[idx]  <= bus_wdata[CW-1:0];
      end
    end
  end

  logic [NREQ-1:0] chg;
  logic [NCH-1:0]  sel, lvl;
  assign chg = req_in ^ req_q;

  always_comb begin
    sel = '0;
    lvl = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < NREQ; r++) begin
        if (chg[r] && map_vld[r] && map_ch[r] == CW'(c)) begin
          sel[c] = 1'b1;
          lvl[c] = req_in[r];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    req_q <= req_in;
    if (!rst_n) begin
      ch_active <= '0;
      ras_pulse <= '0;
      eor_pulse <= '0;
    end else begin
      ras_pulse <= sel & lvl & ~ch_active;
      eor_pulse <= sel & ~lvl & ch_active;
      ch_active <= (ch_active & ~sel) | (sel & lvl);
    end
  end
endmodule

module req_router_chk #(
  parameter int NREQ = 75,
  parameter int NCH  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_in,
  input logic            bus_wen,
  input logic            bus_err,
  input logic [NCH-1:0]  ch_active,
  input logic [NCH-1:0]  ras_pulse,
  input logic [NCH-1:0]  eor_pulse
);
  a_r4_ras_now_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & ~ch_active) == '0);
  a_r4_ras_was_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & $past(ch_active)) == '0);
  a_r5_eor_now_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse & ch_active) == '0);
  a_r5_eor_was_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse & ~$past(ch_active)) == '0);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_pulse & eor_pulse) == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(req_in) |=> $stable(ch_active));
  a_r7_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_wen));
endmodule

bind req_router req_router_chk #(.NREQ(NREQ), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_wen(bus_wen),
  .bus_err(bus_err), .ch_active(ch_active), .ras_pulse(ras_pulse),
  .eor_pulse(eor_pulse)
);

// File: tb/req_router_tb.sv
module req_router_tb;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREQ-1:0] req_in = '0;
  logic            bus_wen = 1'b0;
  logic [15:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_err;
  logic [NCH-1:0]  ch_active, ras_pulse, eor_pulse;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [NCH-1:0] exp_act = '0;

  always #10 clk = ~clk;

  req_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ch_active(ch_active), .ras_pulse(ras_pulse),
    .eor_pulse(eor_pulse)
  );

  // [15:9] line, [8] level, [7:4] channel, [3] active, [2] ras, [1] eor
  localparam logic [15:0] VEC [10] = '{
    {7'd3,  1'b1, 4'd2,  1'b1, 1'b1, 1'b0, 1'b0},
    {7'd10, 1'b1, 4'd2,  1'b1, 1'b0, 1'b0, 1'b0},
    {7'd3,  1'b0, 4'd2,  1'b0, 1'b0, 1'b1, 1'b0},
    {7'd10, 1'b0, 4'd2,  1'b0, 1'b0, 1'b0, 1'b0},
    {7'd70, 1'b1, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'd70, 1'b0, 4'd15, 1'b0, 1'b0, 1'b1, 1'b0},
    {7'd5,  1'b1, 4'd1,  1'b0, 1'b0, 1'b0, 1'b0},
    {7'd5,  1'b0, 4'd1,  1'b0, 1'b0, 1'b0, 1'b0},
    {7'd74, 1'b1, 4'd0,  1'b1, 1'b1, 1'b0, 1'b0},
    {7'd74, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ent_addr(input int k);
    return (k < 64) ? 16'(16'h0100 + 4 * k) : 16'(16'h1100 + 4 * (k - 64));
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
    err = bus_err;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic step(input int line, input logic lvl);
    @(negedge clk);
    req_in[line] = lvl;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R9 reset ch_active", 32'(ch_active), 0);
    chk("R9 reset ras", 32'(ras_pulse), 0);
    chk("R9 reset eor", 32'(eor_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset bus_err", 32'(bus_err), 0);
    rd(16'h0100, d); chk("R1 reset entry 0", d, 0);
    rd(16'h1128, d); chk("R1 reset entry 74", d, 0);

    wr(ent_addr(3), 32'h82, e);  chk("R7 good write no err", 32'(e), 0);
    wr(ent_addr(10), 32'h82, e);
    wr(ent_addr(5), 32'h01, e);
    wr(ent_addr(70), 32'h8F, e);
    wr(ent_addr(74), 32'h80, e);
    rd(16'h1118, d); chk("R2 entry 70 at 0x1118", d, 32'h8F);
    rd(16'h010C, d); chk("R2 entry 3 at 0x10C", d, 32'h82);

    wr(16'h0104, 32'hFFFF_FFE3, e);
    rd(16'h0104, d); chk("R1 readback masks bits", d, 32'h83);

    wr(16'h112C, 32'h81, e);
    rd(16'h112C, d); chk("R2 unmapped read zero", d, 0);
    rd(16'h1128, d); chk("R2 neighbour unchanged", d, 32'h80);
    wr(16'h0102, 32'h81, e);
    rd(16'h0100, d); chk("R2 misaligned write ignored", d, 0);

    wr(16'h0150, 32'h94, e); chk("R7 bad channel err", 32'(e), 1);
    rd(16'h0150, d); chk("R7 bad write not applied", d, 0);

    for (int i = 0; i < 10; i++) begin
      logic [15:0] v;
      int ch;
      v = VEC[i];
      ch = int'(v[7:4]);
      step(int'(v[15:9]), v[8]);
      exp_act[ch] = v[3];
      chk($sformatf("R6 vec %0d active", i), 32'(ch_active), 32'(exp_act));
      chk($sformatf("R4 vec %0d ras", i), 32'(ras_pulse), 32'(v[2]) << ch);
      chk($sformatf("R5 vec %0d eor", i), 32'(eor_pulse), 32'(v[1]) << ch);
      if (v[15:9] == 7'd5)
        chk($sformatf("R3 vec %0d disabled line", i), 32'(ch_active), 0);
    end

    @(negedge clk);
    chk("R4 pulse lasts one cycle", 32'(ras_pulse | eor_pulse), 0);

    step(10, 1'b1);
    chk("R8 setup active", 32'(ch_active), 32'h4);
    @(negedge clk);
    req_in[3] = 1'b1;
    req_in[10] = 1'b0;
    @(negedge clk);
    chk("R8 higher line wins active", 32'(ch_active), 0);
    chk("R8 higher line wins eor", 32'(eor_pulse), 32'h4);
    chk("R8 no ras", 32'(ras_pulse), 0);

    @(negedge clk);
    chk("R6 hold without change", 32'(ch_active), 0);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 held line no event", 32'(ras_pulse | eor_pulse | ch_active), 0);
    rd(16'h010C, d); chk("R1 table cleared by reset", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule